// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading a two-level translation structure held in memory. A caller hands it a 32-bit virtual address and the byte address of a top-level directory. The walker fetches one directory entry, which gives the base of a second-level table. It then fetches one table entry, which gives the physical frame. The frame is joined to the untouched in-page offset to form the result. Pages are 8 KB and each second-level table holds 2048 four-byte entries. There is no intermediate level.

Memory is reached through a minimal port. The walker raises a one-cycle request carrying a byte address. It then waits, with no time limit, for a one-cycle response carrying a 32-bit word. Only one walk is active at a time. A walk ends in a one-cycle completion pulse that carries the physical address, or in a one-cycle fault pulse that names the level whose entry was absent. The walker then becomes idle and accepts new work.

Top module: `ptw_walker`

## Requirements
- R1: After reset, and until a start is accepted, `busy`, `mem_req_valid`, `done` and `fault` are all low.
- R2: The first memory request of a walk reads address `start_root + 4 * vaddr[31:24]`, so each directory entry covers 16 MB.
- R3: When the directory entry has bit 0 set, the second request reads `{dir_entry[31:13], 13'b0} + 4 * vaddr[23:13]`. Each table has 2048 entries.
- R4: When the table entry has bit 0 set, `done` pulses and `result_paddr` equals `{table_entry[31:12+1], vaddr[12:0]}`. Entry bits 12:1 are ignored.
- R5: A directory entry with bit 0 clear ends the walk with `fault` high and `fault_level` = 0. No second request is issued.
- R6: A table entry with bit 0 clear ends the walk with `fault` high and `fault_level` = 1.
- R7: `done` and `fault` are never high together. Each lasts exactly one cycle, and in the following cycle `busy` is low.
- R8: `start_valid` is accepted only while `busy` is low. A start offered during a walk has no effect on that walk's requests or result, and it produces no extra result.
- R9: Each request is high for one cycle. No new request is issued while a response is still owed.
- R10: Virtual address 0xD004000C reads directory index 0xD0 and table index 0x020, and keeps offset 0x00C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start a walk (taken only when not busy) |
| start_vaddr | input | 32 | Virtual address to translate |
| start_root | input | 32 | Byte address of the directory |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | One-cycle read response |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | Translation finished successfully (one cycle) |
| fault | output | 1 | Translation failed (one cycle) |
| fault_level | output | 1 | 0 = directory entry absent, 1 = table entry absent |
| result_paddr | output | 32 | Physical address, valid with `done` |

## Verification
Several properties are checked on every cycle. The quiet state after reset and the single-cycle request are checked, as are the rule that at most one request is outstanding and the form of the directory-entry address. The checks also cover the number of requests seen before each kind of ending, that the offset bits pass through to the result, and that the end pulses are exclusive and one cycle long. Only the bench scenarios can show that the full physical address and the second-level address are built from the entry contents. The same holds for the behaviour under varying memory latency, for the index corner values (all zeros, all ones, the 0xD004000C example), and for starts offered during a walk leaving the result untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_PTE,
    ST_WT_PTE,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_PTE = 1'b1;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int PT_IDX_W = 11,
  parameter int OFF_W    = 13,
  parameter int ENT_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] root,
  input  logic [ADDR_W-1:0] table_base,
  input  logic [ADDR_W-1:0] frame_base,
  output logic [ADDR_W-1:0] dir_ent_addr,
  output logic [ADDR_W-1:0] pte_addr,
  output logic [ADDR_W-1:0] paddr
);
  localparam int DIR_IDX_W = ADDR_W - PT_IDX_W - OFF_W;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [PT_IDX_W-1:0]  pt_idx;

  assign dir_idx = vaddr[ADDR_W-1 -: DIR_IDX_W];
  assign pt_idx  = vaddr[OFF_W +: PT_IDX_W];

  assign dir_ent_addr = root + (ADDR_W'(dir_idx) << ENT_LOG2);
  assign pte_addr     = table_base + (ADDR_W'(pt_idx) << ENT_LOG2);
  assign paddr        = {frame_base[ADDR_W-1:OFF_W], vaddr[OFF_W-1:0]};
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13
) (
  input  logic [ADDR_W-OFF_W-1:0] entry_hi,
  input  logic                    entry_p,
  output logic                    present,
  output logic [ADDR_W-1:0]       base
);
  assign present = entry_p;
  assign base    = {entry_hi, {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_valid,
  input  logic        rsp_valid,
  input  logic        present,
  output walk_state_t state
);
  walk_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start_valid) nxt = ST_RD_DIR;
      ST_RD_DIR: nxt = ST_WT_DIR;
      ST_WT_DIR: if (rsp_valid) nxt = present ? ST_RD_PTE : ST_FAULT;
      ST_RD_PTE: nxt = ST_WT_PTE;
      ST_WT_PTE: if (rsp_valid) nxt = present ? ST_DONE : ST_FAULT;
      ST_DONE:   nxt = ST_IDLE;
      ST_FAULT:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PT_IDX_W = 11,
  parameter int OFF_W    = 13,
  parameter int ENT_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_vaddr,
  input  logic [ADDR_W-1:0] start_root,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [ADDR_W-1:0] result_paddr
);
  walk_state_t       state;
  logic [ADDR_W-1:0] vaddr_q, root_q, tbase_q, paddr_q;
  logic              lvl_q;
  logic              ent_present;
  logic [ADDR_W-1:0] ent_base;
  logic [ADDR_W-1:0] dir_addr_c, pte_addr_c, paddr_c;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .rsp_valid   (mem_rsp_valid),
    .present     (ent_present),
    .state       (state)
  );

  ptw_entry_dec #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .entry_hi (mem_rsp_data[ADDR_W-1:OFF_W]),
    .entry_p  (mem_rsp_data[0]),
    .present  (ent_present),
    .base     (ent_base)
  );

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .PT_IDX_W(PT_IDX_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)
  ) u_agen (
    .vaddr        (vaddr_q),
    .root         (root_q),
    .table_base   (tbase_q),
    .frame_base   (ent_base),
    .dir_ent_addr (dir_addr_c),
    .pte_addr     (pte_addr_c),
    .paddr        (paddr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vaddr_q <= '0;
      root_q  <= '0;
      tbase_q <= '0;
      paddr_q <= '0;
      lvl_q   <= LVL_DIR;
    end else begin
      if (state == ST_IDLE && start_valid) begin
        vaddr_q <= start_vaddr;
        root_q  <= start_root;
      end
      if (state == ST_WT_DIR && mem_rsp_valid) begin
        if (ent_present) tbase_q <= ent_base;
        else             lvl_q   <= LVL_DIR;
      end
      if (state == ST_WT_PTE && mem_rsp_valid) begin
        if (ent_present) paddr_q <= paddr_c;
        else             lvl_q   <= LVL_PTE;
      end
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_RD_DIR) || (state == ST_RD_PTE);
  assign mem_req_addr  = (state == ST_RD_PTE) ? pte_addr_c : dir_addr_c;
  assign done          = (state == ST_DONE);
  assign fault         = (state == ST_FAULT);
  assign fault_level   = lvl_q;
  assign result_paddr  = paddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int PT_IDX_W = 11,
  parameter int OFF_W    = 13,
  parameter int ENT_LOG2 = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_valid,
  input logic [ADDR_W-1:0] start_vaddr,
  input logic [ADDR_W-1:0] start_root,
  input logic              busy,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault,
  input logic              fault_level,
  input logic [ADDR_W-1:0] result_paddr
);
  localparam int DIR_IDX_W = ADDR_W - PT_IDX_W - OFF_W;

  logic [ADDR_W-1:0] va_cap, root_cap;
  logic [1:0]        nreq;
  logic              owed;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_cap <= '0; root_cap <= '0; nreq <= '0; owed <= 1'b0;
    end else begin
      if (start_valid && !busy) begin
        va_cap <= start_vaddr; root_cap <= start_root; nreq <= '0;
      end else if (mem_req_valid && nreq != 2'd3) begin
        nreq <= nreq + 2'd1;
      end
      if (mem_req_valid)      owed <= 1'b1;
      else if (mem_rsp_valid) owed <= 1'b0;
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !mem_req_valid && !done && !fault));
  p_dir_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && nreq == 2'd0) |->
      mem_req_addr == root_cap + (ADDR_W'(va_cap[ADDR_W-1 -: DIR_IDX_W]) << ENT_LOG2));
  p_two_reads_done_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> nreq == 2'd2);
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> result_paddr[OFF_W-1:0] == va_cap[OFF_W-1:0]);
  p_dir_fault_one_read_r5: assert property (@(posedge clk) disable iff (rst)
    (fault && !fault_level) |-> nreq == 2'd1);
  p_pte_fault_two_reads_r6: assert property (@(posedge clk) disable iff (rst)
    (fault && fault_level) |-> nreq == 2'd2);
  p_end_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
  p_end_single_r7: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |=> (!done && !fault && !busy));
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (start_valid && !busy) |=> busy);
  p_req_single_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  p_one_owed_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !owed);
endmodule

bind ptw_walker ptw_walker_chk #(
  .ADDR_W(ADDR_W), .PT_IDX_W(PT_IDX_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)
) u_chk (
  .clk(clk), .rst(rst), .start_valid(start_valid), .start_vaddr(start_vaddr),
  .start_root(start_root), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .done(done),
  .fault(fault), .fault_level(fault_level), .result_paddr(result_paddr)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid = 1'b0;
  logic [31:0] start_vaddr = '0, start_root = '0;
  logic        busy, mem_req_valid, done, fault, fault_level;
  logic [31:0] mem_req_addr, result_paddr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] mem [int unsigned];
  logic [31:0] req_q[$];
  logic [33:0] res_q[$];
  logic [31:0] pend_addr;
  int pend_cnt = 0;
  int lat = 1;
  bit prev_end = 0;

  always #2 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_vaddr(start_vaddr),
    .start_root(start_root), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_level(fault_level), .result_paddr(result_paddr)
  );

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one outstanding read, response after lat cycles
  always @(posedge clk) begin
    if (rst) begin
      pend_cnt <= 0; mem_rsp_valid <= 1'b0;
    end else if (mem_req_valid) begin
      pend_addr <= mem_req_addr; pend_cnt <= lat; mem_rsp_valid <= 1'b0;
    end else if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      mem_rsp_valid <= (pend_cnt == 1);
      mem_rsp_data  <= rd(pend_addr);
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_end)
        chk(!done && !fault && !busy, "R7 pulse/idle", {29'b0, done, fault, busy}, 32'h0);
      prev_end = done || fault;
      if (done && fault) chk(0, "R7 exclusive", 32'h3, 32'h0);
      if (mem_req_valid) begin
        if (req_q.size() == 0) chk(0, "R9/R5 unexpected request", mem_req_addr, 32'h0);
        else begin
          logic [31:0] e;
          e = req_q.pop_front();
          chk(mem_req_addr == e, "R2/R3 request address", mem_req_addr, e);
        end
      end
      if (done || fault) begin
        if (res_q.size() == 0) chk(0, "R8 unexpected result", result_paddr, 32'h0);
        else begin
          logic [33:0] r;
          r = res_q.pop_front();
          if (!r[33]) begin
            chk(done && !fault, "R4 done expected", {31'b0, fault}, 32'h0);
            chk(result_paddr == r[31:0], "R4 physical address", result_paddr, r[31:0]);
          end else begin
            chk(fault && !done, r[32] ? "R6 fault expected" : "R5 fault expected",
                {31'b0, done}, 32'h0);
            chk(fault_level == r[32], r[32] ? "R6 fault level" : "R5 fault level",
                {31'b0, fault_level}, {31'b0, r[32]});
          end
        end
      end
    end
  end

  // driver: computes expectations from the requirements, then starts a walk
  task automatic walk(logic [31:0] va, logic [31:0] root, bit noisy);
    logic [31:0] da, de, pa, pe;
    da = root + {22'b0, va[31:24], 2'b00};
    req_q.push_back(da);
    de = rd(da);
    if (!de[0]) res_q.push_back({2'b10, 32'h0});
    else begin
      pa = {de[31:13], 13'b0} + {19'b0, va[23:13], 2'b00};
      req_q.push_back(pa);
      pe = rd(pa);
      if (!pe[0]) res_q.push_back({2'b11, 32'h0});
      else        res_q.push_back({2'b00, pe[31:13], va[12:0]});
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    start_valid = 1'b1; start_vaddr = va; start_root = root;
    @(negedge clk);
    if (noisy) begin
      // R8: offer different starts while busy
      while (busy) begin
        start_valid = 1'b1; start_vaddr = ~va; start_root = root + 32'h40;
        @(negedge clk);
      end
    end
    start_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(req_q.size() == 0 && res_q.size() == 0, "R8/R9 scoreboard drained",
        req_q.size() + res_q.size(), 32'h0);
  endtask

  initial begin
    // root A at 0x00100000
    mem[32'h0010_0340] = 32'h0020_1FF3;   // dir 0xD0 -> table 0x00200000 (junk low bits)
    mem[32'h0020_0080] = 32'h1234_7FF1;   // pte 0x020 -> frame 0x12346000
    mem[32'h0010_03FC] = 32'h0030_0001;   // dir 0xFF -> table 0x00300000
    mem[32'h0030_1FFC] = 32'hFFFF_E001;   // pte 0x7FF -> frame 0xFFFFE000
    mem[32'h0040_0000] = 32'h0050_0001;   // root B dir 0x00 -> table 0x00500000
    mem[32'h0050_0000] = 32'h0000_2001;   // pte 0x000 -> frame 0x00002000
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !done && !fault, "R1 reset state",
        {28'b0, busy, mem_req_valid, done, fault}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req_valid && !done && !fault, "R1 idle after reset",
        {28'b0, busy, mem_req_valid, done, fault}, 32'h0);
    // R10: example address, indices 0xD0 / 0x020, offset 0x00C
    walk(32'hD004_000C, 32'h0010_0000, 0);
    lat = 5;
    walk(32'hD004_000C, 32'h0010_0000, 0);        // R10 under longer latency
    lat = 2;
    walk(32'h5500_0000, 32'h0010_0000, 0);        // R5 directory absent
    walk(32'hD006_0000, 32'h0010_0000, 0);        // R6 table entry absent
    walk(32'hFFFF_FFFF, 32'h0010_0000, 0);        // R2/R3/R4 all-ones indices
    lat = 1;
    walk(32'h0000_0000, 32'h0040_0000, 0);        // R4 all-zero indices
    lat = 3;
    walk(32'hD004_1FFF, 32'h0010_0000, 1);        // R8 starts while busy
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fault, "R8 no extra walk after noisy starts",
        {29'b0, busy, done, fault}, 32'h0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule